// File: doc/BRIEF.md
# Shared-Memory Doorbell and Interrupt Register Block

This block is the small register window of a device that lets several guests share one memory region and signal each other. Software sees four 32-bit registers: an interrupt enable mask, an interrupt status word that empties itself when read, a read-only word that reports the device's own peer number, and a write-only doorbell. The single level-sensitive interrupt line is high while any status bit is also enabled in the mask.

A doorbell write packs a destination peer and a vector number into one word. The block checks the destination against the number of peer slots and the vector against how many vectors that peer has registered. A write that passes both checks becomes a one-clock notify strobe, with the destination and vector presented beside it. A write that fails either check is dropped without any sign. The per-peer vector counts sit in a small table that the surrounding transport logic fills through its own write port. Incoming event pulses for this device load the status word when message-signalled interrupts are off.

Top module: `peer_doorbell_regs`

## Requirements
- R1: After reset the mask and status words are zero, the interrupt line is low, no notify strobe is raised, and every peer's vector count is zero, so every doorbell is dropped.
- R2: A write decodes its address with the two low bits cleared (address AND 0xFC). A write to offset 0x0 loads the mask, and a read of exactly 0x0 returns it.
- R3: The interrupt line equals the OR of (status AND mask) over all 32 bits. It follows every mask write, status write and status read from the next clock edge onward.
- R4: A read of exactly offset 0x4 returns the current status word, and the word is zero from the next clock edge. A write to 0x4 loads the written value.
- R5: For a doorbell write to 0xC, the destination is bits 31:16 and the vector is bits 7:0. Bits 15:8 have no effect. A valid write raises the notify strobe for exactly the one cycle after the write's clock edge, with the destination and vector on their output ports.
- R6: A doorbell write is dropped, with no strobe, when the destination is not less than NUM_PEERS or the vector is not less than the count stored for that destination.
- R7: A read of exactly 0x8 returns the own-ID input when the shared memory is marked mapped, and 0xFFFFFFFF when it is not.
- R8: Reads of 0xC, of any other unlisted offset and of any offset that is not a multiple of four return zero. Writes to 0x8 and to unlisted offsets change neither the mask nor the status.
- R9: When message-signalled interrupts are disabled, an event pulse writes the value 1 into the status word and replaces its old contents. When they are enabled, an event pulse leaves the status word unchanged.
- R10: An event pulse that counts (R9) takes precedence over a status write or a status read in the same cycle, so the status word holds 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset in the 256-byte window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| shmMapped | input | 1 | Shared memory is mapped |
| ownId | input | 32 | The device's own peer number |
| msiEnable | input | 1 | Message-signalled interrupts enabled |
| eventPulse | input | 1 | Incoming event for this device |
| cntWrEn | input | 1 | Vector-count table write enable |
| cntWrPeer | input | PEER_W | Peer slot to write |
| cntWrVal | input | CNT_W | Vector count for that slot |
| irqOut | output | 1 | Level interrupt |
| notifyPulse | output | 1 | One-cycle notify strobe |
| notifyDest | output | 16 | Destination peer of the strobe |
| notifyVec | output | 8 | Vector of the strobe |

## Verification
The bench keeps the defaults of four peer slots and at most four vectors per peer. With these values it can sweep every destination from 0 to 5 against every vector from 0 to 5, which covers every valid pair, the last valid slot, the first slot past it, and a peer with zero vectors. Junk is placed in bits 15:8 on every one of these writes. The small size also allows a walk of one status bit per nibble against matching and complementary masks. It also lets the bench probe each aligned, unaligned and unlisted offset.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int DEST_W = 16;
  localparam int VEC_W  = 8;

  localparam logic [ADDR_W-1:0] OFF_MASK   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_POS    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_DOOR   = 8'h0C;

  typedef struct packed {
    logic wrMask;
    logic wrStatus;
    logic rdStatus;
    logic wrDoor;
  } strobe_t;

  typedef enum logic [1:0] {
    RD_ZERO,
    RD_MASK,
    RD_STATUS,
    RD_POS
  } rdsel_t;
endpackage

// File: rtl/pdb_ctrl.sv
module pdb_ctrl
  import pdb_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb,
  output rdsel_t            rdSel
);
  logic [ADDR_W-1:0] wrOff;
  logic              doWr;
  logic              doRd;

  assign wrOff = busAddr & 8'hFC;
  assign doWr  = busSel & busWr;
  assign doRd  = busSel & ~busWr;

  always_comb begin
    strb.wrMask   = doWr && (wrOff == OFF_MASK);
    strb.wrStatus = doWr && (wrOff == OFF_STATUS);
    strb.wrDoor   = doWr && (wrOff == OFF_DOOR);
    strb.rdStatus = doRd && (busAddr == OFF_STATUS);
  end

  always_comb begin
    rdSel = RD_ZERO;
    if (doRd) begin
      case (busAddr)
        OFF_MASK:   rdSel = RD_MASK;
        OFF_STATUS: rdSel = RD_STATUS;
        OFF_POS:    rdSel = RD_POS;
        default:    rdSel = RD_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/pdb_vec_table.sv
module pdb_vec_table #(
  parameter int NUM_PEERS = 4,
  parameter int MAX_VEC   = 4,
  localparam int PEER_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
  localparam int CNT_W    = $clog2(MAX_VEC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [PEER_W-1:0] wrPeer,
  input  logic [CNT_W-1:0]  wrVal,
  input  logic [PEER_W-1:0] rdPeer,
  output logic [CNT_W-1:0]  rdCnt
);
  logic [CNT_W-1:0] cntQ [NUM_PEERS];

  for (genvar p = 0; p < NUM_PEERS; p++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[p] <= '0;
      end else if (wrEn && (32'(wrPeer) == p)) begin
        cntQ[p] <= wrVal;
      end
    end
  end

  always_comb begin
    rdCnt = '0;
    for (int p = 0; p < NUM_PEERS; p++) begin
      if (32'(rdPeer) == p) rdCnt = cntQ[p];
    end
  end
endmodule

// File: rtl/pdb_datapath.sv
module pdb_datapath
  import pdb_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int MAX_VEC   = 4,
  localparam int PEER_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
  localparam int CNT_W    = $clog2(MAX_VEC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  rdsel_t            rdSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              shmMapped,
  input  logic [DATA_W-1:0] ownId,
  input  logic              msiEnable,
  input  logic              eventPulse,
  input  logic              cntWrEn,
  input  logic [PEER_W-1:0] cntWrPeer,
  input  logic [CNT_W-1:0]  cntWrVal,
  output logic              irqOut,
  output logic              notifyPulse,
  output logic [DEST_W-1:0] notifyDest,
  output logic [VEC_W-1:0]  notifyVec
);
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] statusQ;
  logic [DATA_W-1:0] statusD;
  logic              evtHit;

  logic [DEST_W-1:0] doorDest;
  logic [VEC_W-1:0]  doorVec;
  logic [CNT_W-1:0]  destCnt;
  logic              destOk;
  logic              vecOk;
  logic              doorFire;

  assign evtHit = eventPulse & ~msiEnable;

  always_comb begin
    statusD = statusQ;
    if (evtHit)             statusD = 32'h1;
    else if (strb.wrStatus) statusD = busWdata;
    else if (strb.rdStatus) statusD = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      statusQ <= '0;
    end else begin
      if (strb.wrMask) maskQ <= busWdata;
      statusQ <= statusD;
    end
  end

  assign irqOut = |(statusQ & maskQ);

  always_comb begin
    case (rdSel)
      RD_MASK:   busRdata = maskQ;
      RD_STATUS: busRdata = statusQ;
      RD_POS:    busRdata = shmMapped ? ownId : 32'hFFFF_FFFF;
      default:   busRdata = '0;
    endcase
  end

  assign doorDest = busWdata[31:16];
  assign doorVec  = busWdata[7:0];

  pdb_vec_table #(
    .NUM_PEERS(NUM_PEERS),
    .MAX_VEC  (MAX_VEC)
  ) u_table (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (cntWrEn),
    .wrPeer(cntWrPeer),
    .wrVal (cntWrVal),
    .rdPeer(doorDest[PEER_W-1:0]),
    .rdCnt (destCnt)
  );

  assign destOk   = 32'(doorDest) < 32'(NUM_PEERS);
  assign vecOk    = 32'(doorVec) < 32'(destCnt);
  assign doorFire = strb.wrDoor & destOk & vecOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      notifyPulse <= 1'b0;
      notifyDest  <= '0;
      notifyVec   <= '0;
    end else begin
      notifyPulse <= doorFire;
      if (doorFire) begin
        notifyDest <= doorDest;
        notifyVec  <= doorVec;
      end
    end
  end

  // R4
  status_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStatus && !evtHit) |=> (statusQ == '0));

  // R9
  event_loads_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtHit |=> (statusQ == 32'h1));

  // R2
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMask |=> (maskQ == $past(busWdata)));

  // R5
  notify_from_door_chk: assert property (@(posedge clk) disable iff (!rstN)
    notifyPulse |-> $past(strb.wrDoor));

  // R6
  notify_dest_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    notifyPulse |-> (32'(notifyDest) < 32'(NUM_PEERS)));
endmodule

// File: rtl/peer_doorbell_regs.sv
module peer_doorbell_regs
  import pdb_pkg::*;
#(
  parameter int NUM_PEERS = 4,
  parameter int MAX_VEC   = 4,
  localparam int PEER_W   = (NUM_PEERS > 1) ? $clog2(NUM_PEERS) : 1,
  localparam int CNT_W    = $clog2(MAX_VEC + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              shmMapped,
  input  logic [31:0]       ownId,
  input  logic              msiEnable,
  input  logic              eventPulse,
  input  logic              cntWrEn,
  input  logic [PEER_W-1:0] cntWrPeer,
  input  logic [CNT_W-1:0]  cntWrVal,
  output logic              irqOut,
  output logic              notifyPulse,
  output logic [15:0]       notifyDest,
  output logic [7:0]        notifyVec
);
  strobe_t strb;
  rdsel_t  rdSel;

  pdb_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb),
    .rdSel  (rdSel)
  );

  pdb_datapath #(
    .NUM_PEERS(NUM_PEERS),
    .MAX_VEC  (MAX_VEC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .rdSel      (rdSel),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .shmMapped  (shmMapped),
    .ownId      (ownId),
    .msiEnable  (msiEnable),
    .eventPulse (eventPulse),
    .cntWrEn    (cntWrEn),
    .cntWrPeer  (cntWrPeer),
    .cntWrVal   (cntWrVal),
    .irqOut     (irqOut),
    .notifyPulse(notifyPulse),
    .notifyDest (notifyDest),
    .notifyVec  (notifyVec)
  );
endmodule

// File: tb/peer_doorbell_regs_tb.sv
module peer_doorbell_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int MV = 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        busSel, busWr;
  logic [7:0]  busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata;
  logic        shmMapped;
  logic [31:0] ownId;
  logic        msiEnable, eventPulse;
  logic        cntWrEn;
  logic [1:0]  cntWrPeer;
  logic [2:0]  cntWrVal;
  logic        irqOut, notifyPulse;
  logic [15:0] notifyDest;
  logic [7:0]  notifyVec;

  int errors = 0;
  int checks = 0;
  int cnt [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_doorbell_regs #(.NUM_PEERS(NP), .MAX_VEC(MV)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .shmMapped(shmMapped), .ownId(ownId), .msiEnable(msiEnable),
    .eventPulse(eventPulse), .cntWrEn(cntWrEn), .cntWrPeer(cntWrPeer),
    .cntWrVal(cntWrVal), .irqOut(irqOut), .notifyPulse(notifyPulse),
    .notifyDest(notifyDest), .notifyVec(notifyVec)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic pulseEvent();
    @(negedge clk);
    eventPulse = 1'b1;
    @(negedge clk);
    eventPulse = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; busSel = 0; busWr = 0; busAddr = 0; busWdata = 0;
    shmMapped = 0; ownId = 32'h0000_0002; msiEnable = 0; eventPulse = 0;
    cntWrEn = 0; cntWrPeer = 0; cntWrVal = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    chk(irqOut == 1'b0, "R1 irq", {31'd0, irqOut}, 32'd0);
    chk(notifyPulse == 1'b0, "R1 notify", {31'd0, notifyPulse}, 32'd0);
    busRead(8'h00, rd); chk(rd == 0, "R1 mask", rd, 0);
    busRead(8'h04, rd); chk(rd == 0, "R1 status", rd, 0);
    busWrite(8'h0C, 32'h0000_0000);
    chk(notifyPulse == 1'b0, "R1 zero counts drop", {31'd0, notifyPulse}, 32'd0);

    // R2 write address masking and readback
    busWrite(8'h01, 32'hDEAD_BEEF);
    busRead(8'h00, rd); chk(rd == 32'hDEAD_BEEF, "R2 masked write", rd, 32'hDEAD_BEEF);
    busWrite(8'h00, 32'h0000_0000);

    // R3 irq sweep, one bit per nibble against matching and complementary masks
    for (int i = 0; i < 8; i++) begin
      logic [31:0] st, mk;
      st = 32'h1 << (i * 4);
      mk = (i % 2 == 1) ? (st | 32'h0F00_0000) : ~st;
      busWrite(8'h04, st);
      busWrite(8'h00, mk);
      chk(irqOut == (|(st & mk)), "R3 irq level", {31'd0, irqOut}, {31'd0, |(st & mk)});
    end

    // R4 read clears status and lowers irq
    busWrite(8'h00, 32'hFFFF_FFFF);
    busWrite(8'h04, 32'h1234_5678);
    chk(irqOut == 1'b1, "R3 irq high", {31'd0, irqOut}, 32'd1);
    busRead(8'h04, rd); chk(rd == 32'h1234_5678, "R4 read value", rd, 32'h1234_5678);
    chk(irqOut == 1'b0, "R4 irq after clear", {31'd0, irqOut}, 32'd0);
    busRead(8'h04, rd); chk(rd == 0, "R4 cleared", rd, 0);

    // R8 unlisted / unaligned / position writes
    busWrite(8'h04, 32'h0000_00A0);
    busRead(8'h05, rd); chk(rd == 0, "R8 unaligned read", rd, 0);
    busRead(8'h0C, rd); chk(rd == 0, "R8 doorbell read", rd, 0);
    busRead(8'h40, rd); chk(rd == 0, "R8 unlisted read", rd, 0);
    busWrite(8'h08, 32'h5555_5555);
    busWrite(8'h20, 32'h6666_6666);
    busRead(8'h00, rd); chk(rd == 32'hFFFF_FFFF, "R8 mask untouched", rd, 32'hFFFF_FFFF);
    busRead(8'h04, rd); chk(rd == 32'h0000_00A0, "R8 status untouched (unaligned read no clear)", rd, 32'hA0);

    // R7 position
    busRead(8'h08, rd); chk(rd == 32'hFFFF_FFFF, "R7 unmapped", rd, 32'hFFFF_FFFF);
    shmMapped = 1'b1;
    busRead(8'h08, rd); chk(rd == 32'h2, "R7 mapped", rd, 32'h2);

    // R9 event load and MSI gating
    busWrite(8'h04, 32'h0000_00F0);
    pulseEvent();
    busRead(8'h04, rd); chk(rd == 32'h1, "R9 event writes one", rd, 32'h1);
    busWrite(8'h04, 32'h0000_00F0);
    msiEnable = 1'b1;
    pulseEvent();
    msiEnable = 1'b0;
    busRead(8'h04, rd); chk(rd == 32'hF0, "R9 msi ignores event", rd, 32'hF0);

    // R10 event beats status write and status read
    @(negedge clk);
    busSel = 1; busWr = 1; busAddr = 8'h04; busWdata = 32'h55; eventPulse = 1;
    @(negedge clk);
    busSel = 0; busWr = 0; eventPulse = 0;
    busRead(8'h04, rd); chk(rd == 32'h1, "R10 event over write", rd, 32'h1);
    @(negedge clk);
    busSel = 1; busWr = 0; busAddr = 8'h04; eventPulse = 1;
    @(negedge clk);
    busSel = 0; eventPulse = 0;
    busRead(8'h04, rd); chk(rd == 32'h1, "R10 event over read", rd, 32'h1);

    // Load vector counts: peer p -> p+1 for p<3, peer 3 -> 0
    for (int p = 0; p < NP; p++) begin
      cnt[p] = (p < 3) ? p + 1 : 0;
      @(negedge clk);
      cntWrEn = 1; cntWrPeer = 2'(p); cntWrVal = 3'(cnt[p]);
    end
    @(negedge clk);
    cntWrEn = 0;

    // R5 R6 doorbell sweep
    for (int d = 0; d < 6; d++) begin
      for (int v = 0; v < 6; v++) begin
        logic expFire;
        logic [31:0] w;
        expFire = (d < NP) && (v < cnt[d % NP]) && (d < NP);
        w = {16'(d), 8'(8'hA5 ^ 8'(d * 6 + v)), 8'(v)};
        busWrite(8'h0C, w);
        chk(notifyPulse == expFire, "R6 doorbell filter", {31'd0, notifyPulse}, {31'd0, expFire});
        if (expFire) begin
          chk(notifyDest == 16'(d), "R5 dest field", {16'd0, notifyDest}, d);
          chk(notifyVec == 8'(v), "R5 vec field", {24'd0, notifyVec}, v);
        end
        @(negedge clk);
        chk(notifyPulse == 1'b0, "R5 one-cycle strobe", {31'd0, notifyPulse}, 32'd0);
      end
    end

    // R6 high destination bits must not alias into a valid slot
    busWrite(8'h0C, 32'h0100_0000);
    chk(notifyPulse == 1'b0, "R6 aliased dest", {31'd0, notifyPulse}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule